// File: doc/BRIEF.md
# Dual Comparator Change-Detect Interrupt

This block is the digital side of a pair of analog comparators. Each comparator's decision arrives as one raw logic level. The level is 1 while the positive input is above the negative input and 0 otherwise. For each channel the block brings that level into the clock domain and presents it as a readable result bit. When an output-enable bit is set, it also drives the result to a pin.

Any change of a channel's synchronized result, rising or falling, sets that channel's sticky flag. Software clears the flag by writing 0 to it. Both channels share one interrupt request, so software reads the per-channel flags to learn which channel fired. While the system is dozing, that same request is also presented as a wake request.

A deep power-off input shuts both channels down so that they produce no flag and no interrupt. After a channel is enabled, a settling counter ignores changes for a parameterised number of cycles. This hides the unstable interval that follows power-up.

Top module: `cmp_pair_irq`

## Requirements
- R1: `cmp_out[i]` equals the raw input `cmp_raw[i]` delayed by two clock cycles while channel i is active (enable bit set and `deep_off` low). It is 0 while the channel is inactive, and an inactive channel sets no flag.
- R2: A rising change of an active, settled channel's synchronized result sets its flag (register bit 3) three clock edges after the raw input changes.
- R3: A falling change of an active, settled channel's synchronized result also sets its flag.
- R4: A flag stays set until a write to that channel's register has bit 3 = 0. A write with bit 3 = 1 leaves the flag unchanged.
- R5: If a change sets the flag in the same cycle as a clearing write, the flag ends up set.
- R6: `irq` is high exactly when some channel has both its flag and its interrupt-enable bit (bit 1) set.
- R7: A channel's flag is set and readable even when its interrupt-enable bit is 0.
- R8: While `deep_off` is high, both result bits and both pins read 0, and no input activity sets a flag or raises `irq`. Releasing `deep_off` does not set a flag by itself.
- R9: `wake` is high when `irq` is high and `doze` is high, and low otherwise.
- R10: `pin_out[i]` follows channel i's result when its output-enable bit (bit 2) is 1, and is 0 when that bit is 0.
- R11: For SETTLE_CYCLES cycles after a channel becomes active, changes of its result set no flag. Changes after that interval do set the flag.
- R12: Reading a channel returns bit 0 = enable, bit 1 = interrupt enable, bit 2 = output enable, bit 3 = flag, bit 4 = result, and 0 in bits 7..5. After reset every bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | NUM_CH | Raw comparator decisions, asynchronous |
| deep_off | input | 1 | Forces all channels inactive |
| doze | input | 1 | System is in a low-power wait state |
| reg_wr | input | 1 | Write strobe for the addressed channel register |
| reg_addr | input | ADDR_W | Channel select for both read and write |
| reg_wdata | input | 4 | Write data: enable, interrupt enable, output enable, flag keep |
| reg_rdata | output | 8 | Read data of the addressed channel |
| cmp_out | output | NUM_CH | Synchronized result bits |
| pin_out | output | NUM_CH | Result driven to pins under output enable |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request while dozing |

## Verification
Every channel is driven through a rising and then a falling change. This separates the both-edge detection from a single-edge design and shows that a change in one channel does not leak into the other channel's flag. All four interrupt-enable combinations are swept with both flags set, and each is tried with and without doze, so the shared OR, the per-channel masking and the wake gating can be told apart. Further patterns cover four cases: a toggle timed to land on a clearing write (priority), a toggle inside the settling window against one after it, a toggle while deep_off is held, and a toggle on a disabled channel. Each of these separates a correctly masked source of flags from a spurious one.

// File: rtl/cmp_pair_pkg.sv
package cmp_pair_pkg;

    localparam int REG_W  = 8;
    localparam int F_EN   = 0;
    localparam int F_IE   = 1;
    localparam int F_OE   = 2;
    localparam int F_FLAG = 3;
    localparam int F_RES  = 4;

    typedef struct packed {
        logic oe;
        logic ie;
        logic en;
    } ch_cfg_t;

    typedef struct packed {
        logic res;
        logic flag;
    } ch_stat_t;

    function automatic logic [REG_W-1:0] pack_reg(ch_cfg_t c, ch_stat_t s);
        logic [REG_W-1:0] r;
        r         = '0;
        r[F_EN]   = c.en;
        r[F_IE]   = c.ie;
        r[F_OE]   = c.oe;
        r[F_FLAG] = s.flag;
        r[F_RES]  = s.res;
        return r;
    endfunction

    function automatic ch_cfg_t unpack_cfg(logic [F_FLAG:0] w);
        ch_cfg_t c;
        c.en = w[F_EN];
        c.ie = w[F_IE];
        c.oe = w[F_OE];
        return c;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
    import cmp_pair_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    input  ch_cfg_t  cfg,
    input  logic     force_off,
    input  logic     clr_req,
    output ch_stat_t stat,
    output logic     pin
);
    localparam int CW = (SETTLE_CYCLES > 0) ? $clog2(SETTLE_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

    logic          sync_q;
    logic          prev_q;
    logic          flag_q;
    logic [CW-1:0] settle_cnt;
    logic          active;
    logic          settled;
    logic          change;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sync_q)
    );

    assign active  = cfg.en & ~force_off;
    assign settled = (settle_cnt == '0);
    assign change  = active & settled & (sync_q != prev_q);

    // settle window restarts every time the channel is inactive
    always_ff @(posedge clk) begin
        if (rst || !active)   settle_cnt <= LOAD;
        else if (!settled)    settle_cnt <= settle_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q;
    end

    // change beats a clearing write
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (change)  flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign stat.flag = flag_q;
    assign stat.res  = active & sync_q;
    assign pin       = stat.res & cfg.oe;

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr_req |=> flag_q);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr_req && !change |=> !flag_q);
    p_change_sets_r2: assert property (@(posedge clk) disable iff (rst)
        active && settled && (sync_q != prev_q) |=> flag_q);
    p_off_no_flag_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> !$rose(flag_q));
    p_settle_mask_r11: assert property (@(posedge clk) disable iff (rst)
        (settle_cnt != '0) |=> !$rose(flag_q));
endmodule

// File: rtl/cmp_pair_irq.sv
module cmp_pair_irq
    import cmp_pair_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int SETTLE_CYCLES = 4,
    parameter int SYNC_STAGES   = 2,
    localparam int ADDR_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] cmp_raw,
    input  logic              deep_off,
    input  logic              doze,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [F_FLAG:0]   reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] cmp_out,
    output logic [NUM_CH-1:0] pin_out,
    output logic              irq,
    output logic              wake
);
    ch_cfg_t     cfg_q  [NUM_CH];
    ch_stat_t    stat_w [NUM_CH];
    logic [NUM_CH-1:0] pend;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        logic clr;

        assign sel = reg_wr && (reg_addr == ADDR_W'(i));
        assign clr = sel && !reg_wdata[F_FLAG];

        always_ff @(posedge clk) begin
            if (rst)      cfg_q[i] <= '0;
            else if (sel) cfg_q[i] <= unpack_cfg(reg_wdata);
        end

        cmp_chan #(
            .SETTLE_CYCLES (SETTLE_CYCLES),
            .SYNC_STAGES   (SYNC_STAGES)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .raw       (cmp_raw[i]),
            .cfg       (cfg_q[i]),
            .force_off (deep_off),
            .clr_req   (clr),
            .stat      (stat_w[i]),
            .pin       (pin_out[i])
        );

        assign cmp_out[i] = stat_w[i].res;
        assign pend[i]    = stat_w[i].flag & cfg_q[i].ie;
    end

    assign irq  = |pend;
    assign wake = irq & doze;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = pack_reg(cfg_q[i], stat_w[i]);
    end

    p_deep_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        deep_off |-> (pin_out == '0) && (cmp_out == '0));
    p_pin_needs_result_r10: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~cmp_out) == '0);
endmodule

// File: tb/tb_cmp_pair_irq.sv
module tb_cmp_pair_irq;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0] raw = '0;
    logic       deep_off = 1'b0;
    logic       doze = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] cmp_out, pin_out;
    logic       irq, wake;
    logic [7:0] d;

    int checks = 0;
    int fails  = 0;

    cmp_pair_irq #(.NUM_CH(2), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst(rst), .cmp_raw(raw), .deep_off(deep_off), .doze(doze),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_out(cmp_out), .pin_out(pin_out),
        .irq(irq), .wake(wake)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int ch, logic oe, logic ie, logic en, logic keep);
        reg_addr  = 1'(ch);
        reg_wdata = {keep, oe, ie, en};
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(int ch);
        reg_addr = 1'(ch);
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R12 reset state
        rd(0); chk("R12 reset ch0", d, 0);
        rd(1); chk("R12 reset ch1", d, 0);
        chk("R12 reset irq", irq, 0);

        wr(0, 0, 1, 1, 1);
        wr(1, 0, 1, 1, 1);
        cyc(SETTLE + 4);
        rd(0); chk("R12 readback ch0", d, 8'h03);

        // both-edge sweep per channel
        for (int ch = 0; ch < 2; ch++) begin
            for (int step = 0; step < 2; step++) begin
                raw[ch] = ~raw[ch];
                cyc(4);
                rd(ch);
                chk(step == 0 ? "R2 rise flag" : "R3 fall flag", d[3], 1);
                chk("R1 result bit", d[4], raw[ch]);
                chk("R1 cmp_out", cmp_out[ch], raw[ch]);
                rd(1 - ch); chk("R2 other flag clear", d[3], 0);
                chk("R6 irq set", irq, 1);
                wr(ch, 0, 1, 1, 1);
                rd(ch); chk("R4 keep write", d[3], 1);
                wr(ch, 0, 1, 1, 0);
                rd(ch); chk("R4 clear write", d[3], 0);
                chk("R6 irq clear", irq, 0);
            end
        end

        // interrupt-enable mask sweep with wake
        for (int m = 0; m < 4; m++) begin
            wr(0, 0, m[0], 1, 0);
            wr(1, 0, m[1], 1, 0);
            raw = raw ^ 2'b11;
            cyc(4);
            rd(0); chk("R7 flag ch0 readable", d[3], 1);
            rd(1); chk("R7 flag ch1 readable", d[3], 1);
            chk("R6 irq mask", irq, (m != 0));
            for (int s = 0; s < 2; s++) begin
                doze = s[0];
                #1;
                chk("R9 wake", wake, (m != 0) && (s != 0));
            end
            doze = 1'b0;
        end
        wr(0, 0, 1, 1, 0);
        wr(1, 0, 1, 1, 0);

        // output enable
        wr(0, 1, 1, 1, 1);
        raw[0] = 1'b1;
        cyc(4);
        chk("R10 pin on", pin_out[0], 1);
        chk("R10 other pin", pin_out[1], 0);
        wr(0, 0, 1, 1, 1);
        chk("R10 pin off", pin_out[0], 0);
        chk("R10 result kept", cmp_out[0], 1);
        raw[0] = 1'b0;
        cyc(4);
        wr(0, 0, 1, 1, 0);

        // disabled channel
        wr(1, 0, 1, 0, 0);
        raw[1] = 1'b1;
        cyc(4);
        chk("R1 disabled out", cmp_out[1], 0);
        rd(1); chk("R1 disabled no flag", d[3], 0);

        // settle window
        raw[1] = 1'b0;
        wr(1, 0, 1, 1, 1);
        cyc(10);
        rd(1); chk("R11 masked in window", d[3], 0);
        chk("R11 result tracks", cmp_out[1], 0);
        raw[1] = 1'b1;
        cyc(4);
        rd(1); chk("R11 flag after window", d[3], 1);
        wr(1, 0, 1, 1, 0);

        // change vs clear in same cycle
        raw[0] = 1'b1;
        cyc(2);
        wr(0, 0, 1, 1, 0);
        rd(0); chk("R5 change wins", d[3], 1);
        wr(0, 0, 1, 1, 0);
        rd(0); chk("R5 later clear", d[3], 0);

        // deep power-off
        wr(0, 1, 1, 1, 0);
        deep_off = 1'b1;
        raw = raw ^ 2'b11;
        cyc(6);
        rd(0); chk("R8 no flag ch0", d[3], 0);
        rd(1); chk("R8 no flag ch1", d[3], 0);
        chk("R8 outputs zero", cmp_out, 0);
        chk("R8 pins zero", pin_out, 0);
        chk("R8 irq low", irq, 0);
        deep_off = 1'b0;
        cyc(SETTLE + 4);
        rd(0); chk("R8 release no flag", d[3], 0);
        chk("R8 result back", cmp_out, raw);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule